// File: doc/BRIEF.md
# Multi-queue credit return scanner

This block returns per-channel flow-control credits that the host hands back through free buffer queues. It watches the host's queue-write completions. When a write completes on a queue that is set up to return credits, that queue becomes active. For every queue the block keeps a forward pointer of its own, separate from the pointer used to consume buffers. For an active queue it fetches the credit word of the entry at that pointer from an external synchronous RAM. While the entry's valid flag is set, it emits one increment strobe for the channel named in the word and moves the pointer on.

Several queues can be active at once. A mode bit picks one of two ways to choose between them. In strict mode the highest-numbered active queue is emptied first. In rotating mode the queues take turns, one entry per turn. The host loads every forward pointer before it enables the block. It can also reload a pointer at any later time.

Top module: `crs_scanner`

## Requirements
- R1: While reset is asserted and just after it is released, `mem_rd` and `cred_inc` are low, and every queue is inactive.
- R2: The credit word has the forward-valid flag at bit CHW+1, the flow-control flag at bit CHW and the channel index in bits CHW-1:0. A word with the valid flag 1 and the flow-control flag 0 produces exactly one `cred_inc` pulse carrying that channel. The pulse comes two cycles after the read that fetched the word.
- R3: A read is issued at `mem_addr` = {queue, forward pointer}. The pointer moves up by one for every entry whose valid flag is 1. After `cfg_qsize`-1 it wraps to 0.
- R4: The walk of a queue stops at the first entry whose valid flag is 0. That queue goes inactive, and its pointer stays on that entry.
- R5: A `snoop_wr` pulse makes queue `snoop_q` active only when `cfg_en` is high and `snoop_q` < `cfg_fwd_cnt`. In every other case the pulse is ignored and no read of that queue follows.
- R6: With `cfg_rr` = 0, each read goes to the highest-numbered active queue.
- R7: With `cfg_rr` = 1, each grant covers one entry. The next grant goes to the next active queue above the last granted one, in ascending order with wrap-around. The last-granted index starts at NQ-1 after reset and is updated on every grant in both modes.
- R8: A word with the valid flag 1 and the flow-control flag 1 produces no credit, but the pointer still advances.
- R9: `ptr_ld` loads `ptr_ld_val` into the pointer of queue `ptr_ld_q`. If the same queue advances in the same cycle, the load wins.
- R10: If a snoop of a queue arrives in the same cycle in which that queue's walk hits its end entry, the queue stays active and the end entry is read again.
- R11: While `cfg_en` is low, no read is issued. A read already in flight still completes, and the walk resumes once `cfg_en` returns high.
- R12: During a walk, a read is issued every second cycle, so two reads are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Scanner enable |
| cfg_rr | input | 1 | Arbitration mode: 0 strict highest first, 1 rotating |
| cfg_fwd_cnt | input | QW+1 | Number of queues, counted from queue 0, that return credits |
| cfg_qsize | input | PW+1 | Entries per queue; the wrap point of the pointers |
| ptr_ld | input | 1 | Load strobe for a forward pointer |
| ptr_ld_q | input | QW | Queue whose pointer is loaded |
| ptr_ld_val | input | PW | Value loaded |
| snoop_wr | input | 1 | Host write completion on a free buffer queue |
| snoop_q | input | QW | Queue of the completed write |
| mem_rd | output | 1 | Read strobe to the entry RAM |
| mem_addr | output | QW+PW | Entry address {queue, index} |
| mem_rdata | input | CHW+2 | Credit word, valid one cycle after the read |
| cred_inc | output | 1 | Increment strobe for a channel's receive counter |
| cred_chan | output | CHW | Channel to increment |

## Verification
A wrong pointer or a wrong active flag shows up at `mem_addr` or `mem_rd` in the very next grant cycle. A wrong arbitration state picks the wrong queue in that same cycle. A misread credit word shows up on `cred_inc` or `cred_chan` two cycles after its read. For these reasons the bench compares the read port and the credit port against its model on every clock, so a fault is caught within two cycles of its cause. It also checks the order of credits across queues, which exposes faults in the priority and rotation logic.

// File: rtl/crs_pkg.sv
// Shared types for the credit return scanner.
// Assumes: nothing beyond a SystemVerilog 2017 tool.
package crs_pkg;

    // Two-phase walk: pick a queue and issue a read, then evaluate the word.
    typedef enum logic {
        ST_PICK = 1'b0,
        ST_EVAL = 1'b1
    } crs_state_e;

    // Decoded credit word.
    typedef struct packed {
        logic fwd_ok;
        logic hold;
    } crs_flags_t;

endpackage

// File: rtl/crs_active_set.sv
// Active flag per queue: set by an accepted snoop, cleared when a walk finds
// the end entry. If both happen to one queue in the same cycle, the set wins,
// because the new write may have placed fresh credit entries.
// Assumes: set_q and clr_q are valid indices below NQ.
module crs_active_set #(
    parameter int NQ = 8,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [QW-1:0] set_q,
    input  logic          clr_en,
    input  logic [QW-1:0] clr_q,
    output logic [NQ-1:0] active
);

    for (genvar g = 0; g < NQ; g++) begin : g_flag
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_en && (set_q == QW'(g));
        assign hit_clr = clr_en && (clr_q == QW'(g));

        // Update one queue's active flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active[g] <= 1'b0;
            end else if (hit_set) begin
                active[g] <= 1'b1;
            end else if (hit_clr) begin
                active[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crs_fwd_ptrs.sv
// Bank of forward read pointers, one per queue, kept apart from buffer usage.
// A pointer advances by one per accepted entry and wraps at the queue size.
// A host load overrides an advance of the same queue in the same cycle.
// Assumes: qsize is in 1..2**PW, and loaded values are below qsize.
module crs_fwd_ptrs #(
    parameter int NQ     = 8,
    parameter int QDEPTH = 64,
    localparam int QW = $clog2(NQ),
    localparam int PW = $clog2(QDEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW:0]      qsize,
    input  logic             ld_en,
    input  logic [QW-1:0]    ld_q,
    input  logic [PW-1:0]    ld_val,
    input  logic             adv_en,
    input  logic [QW-1:0]    adv_q,
    output logic [NQ*PW-1:0] ptrs
);

    for (genvar g = 0; g < NQ; g++) begin : g_ptr
        logic [PW-1:0] cur;
        logic [PW:0]   inc;
        logic [PW-1:0] wrapped;

        assign inc     = {1'b0, cur} + {{PW{1'b0}}, 1'b1};
        assign wrapped = (inc == qsize) ? '0 : inc[PW-1:0];
        assign ptrs[g*PW +: PW] = cur;

        // Hold, advance with wrap, or load one queue's forward pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur <= '0;
            end else if (ld_en && (ld_q == QW'(g))) begin
                cur <= ld_val;
            end else if (adv_en && (adv_q == QW'(g))) begin
                cur <= wrapped;
            end
        end
    end

endmodule

// File: rtl/crs_arbiter.sv
// Chooses one active queue per grant. Strict mode takes the highest index.
// Rotating mode takes the first active index above the last grant, with
// wrap-around. The last grant is recorded on every grant in both modes.
// Assumes: NQ is a power of two and at least 2.
module crs_arbiter #(
    parameter int NQ = 8,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] active,
    input  logic          rr_mode,
    input  logic          take,
    output logic [QW-1:0] grant,
    output logic          any
);

    logic [QW-1:0] last_q;
    logic [QW-1:0] hi_pick;
    logic [QW-1:0] rr_pick;

    assign any   = |active;
    assign grant = rr_mode ? rr_pick : hi_pick;

    // Strict priority: the highest set index wins.
    always_comb begin
        hi_pick = '0;
        for (int i = 0; i < NQ; i++) begin
            if (active[i]) hi_pick = QW'(i);
        end
    end

    // Rotating priority: search upward from the queue after the last grant.
    always_comb begin
        logic found;
        int   idx;
        rr_pick = '0;
        found   = 1'b0;
        idx     = 0;
        for (int i = 1; i <= NQ; i++) begin
            idx = (int'(last_q) + i) % NQ;
            if (!found && active[idx]) begin
                rr_pick = QW'(idx);
                found   = 1'b1;
            end
        end
    end

    // Record the granted queue so that rotation resumes after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= QW'(NQ - 1);
        end else if (take) begin
            last_q <= grant;
        end
    end

endmodule

// File: rtl/crs_scanner.sv
// Credit return scanner top. Snoops host write completions on credit-returning
// free buffer queues, walks each active queue from its forward pointer through
// an external synchronous RAM (one-cycle read latency), and emits one counter
// increment strobe per valid credit word. Each entry takes two cycles: pick and
// read, then evaluate.
// Assumes: the RAM returns word {valid, flow_ctl, channel} on mem_rdata in the
// cycle after mem_rd; the host loads the pointers before raising cfg_en.
module crs_scanner
    import crs_pkg::*;
#(
    parameter int NQ     = 8,
    parameter int QDEPTH = 64,
    parameter int CHW    = 10,
    localparam int QW = $clog2(NQ),
    localparam int PW = $clog2(QDEPTH),
    localparam int WW = CHW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_rr,
    input  logic [QW:0]      cfg_fwd_cnt,
    input  logic [PW:0]      cfg_qsize,
    input  logic             ptr_ld,
    input  logic [QW-1:0]    ptr_ld_q,
    input  logic [PW-1:0]    ptr_ld_val,
    input  logic             snoop_wr,
    input  logic [QW-1:0]    snoop_q,
    output logic             mem_rd,
    output logic [QW+PW-1:0] mem_addr,
    input  logic [WW-1:0]    mem_rdata,
    output logic             cred_inc,
    output logic [CHW-1:0]   cred_chan
);

    crs_state_e    state;
    logic [QW-1:0] cur_q;
    logic [NQ-1:0] active;
    logic [NQ*PW-1:0] ptrs;
    logic [QW-1:0] grant_q;
    logic          any_active;
    logic          issue;
    logic          in_eval;
    crs_flags_t    flags;
    logic [CHW-1:0] word_chan;
    logic          snoop_ok;
    logic          step_adv;
    logic          step_end;
    logic [PW-1:0] grant_ptr;

    // Field split of the credit word.
    assign flags.fwd_ok = mem_rdata[CHW+1];
    assign flags.hold   = mem_rdata[CHW];
    assign word_chan    = mem_rdata[CHW-1:0];

    assign in_eval  = (state == ST_EVAL);
    assign issue    = (state == ST_PICK) && cfg_en && any_active;
    assign step_adv = in_eval && flags.fwd_ok;
    assign step_end = in_eval && !flags.fwd_ok;
    assign snoop_ok = snoop_wr && cfg_en && ({1'b0, snoop_q} < cfg_fwd_cnt);

    assign grant_ptr = ptrs[int'(grant_q)*PW +: PW];
    assign mem_rd    = issue;
    assign mem_addr  = {grant_q, grant_ptr};

    crs_active_set #(.NQ(NQ)) u_active (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (snoop_ok),
        .set_q  (snoop_q),
        .clr_en (step_end),
        .clr_q  (cur_q),
        .active (active)
    );

    crs_fwd_ptrs #(.NQ(NQ), .QDEPTH(QDEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .qsize  (cfg_qsize),
        .ld_en  (ptr_ld),
        .ld_q   (ptr_ld_q),
        .ld_val (ptr_ld_val),
        .adv_en (step_adv),
        .adv_q  (cur_q),
        .ptrs   (ptrs)
    );

    crs_arbiter #(.NQ(NQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .rr_mode (cfg_rr),
        .take    (issue),
        .grant   (grant_q),
        .any     (any_active)
    );

    // Walk sequencer: move to evaluate after a read, back to pick after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PICK;
            cur_q <= '0;
        end else if (in_eval) begin
            state <= ST_PICK;
        end else if (issue) begin
            state <= ST_EVAL;
            cur_q <= grant_q;
        end
    end

    // Credit strobe: one pulse for each valid word whose flow-control flag is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_inc  <= 1'b0;
            cred_chan <= '0;
        end else begin
            cred_inc <= step_adv && !flags.hold;
            if (step_adv && !flags.hold) begin
                cred_chan <= word_chan;
            end
        end
    end

endmodule

// File: rtl/crs_scanner_chk.sv
// Temporal checks on the scanner's ports, attached by bind below.
// Assumes: the host keeps loaded pointers below cfg_qsize.
module crs_scanner_chk #(
    parameter int QW = 3,
    parameter int PW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [PW:0]      cfg_qsize,
    input logic             mem_rd,
    input logic [QW+PW-1:0] mem_addr,
    input logic             cred_inc
);

    assert_cred_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cred_inc |-> $past(mem_rd, 2));

    assert_read_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_cred_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cred_inc |=> !cred_inc);

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !mem_rd);

    assert_index_in_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ({1'b0, mem_addr[PW-1:0]} < cfg_qsize));

endmodule

bind crs_scanner crs_scanner_chk #(.QW(QW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_qsize (cfg_qsize),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .cred_inc  (cred_inc)
);

// File: tb/tb_crs_scanner.sv
// Bench for crs_scanner: behavioural RAM, cycle-by-cycle reference model,
// and scenario checks on credit counts, order and read addresses.
module tb_crs_scanner;

    localparam int NQ = 8, QDEPTH = 64, CHW = 10;
    localparam int QW = $clog2(NQ), PW = $clog2(QDEPTH), WW = CHW + 2;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_en, cfg_rr;
    logic [QW:0] cfg_fwd_cnt;
    logic [PW:0] cfg_qsize;
    logic ptr_ld;
    logic [QW-1:0] ptr_ld_q;
    logic [PW-1:0] ptr_ld_val;
    logic snoop_wr;
    logic [QW-1:0] snoop_q;
    logic mem_rd;
    logic [QW+PW-1:0] mem_addr;
    logic [WW-1:0] mem_rdata;
    logic cred_inc;
    logic [CHW-1:0] cred_chan;

    always #4 clk = ~clk;

    crs_scanner #(.NQ(NQ), .QDEPTH(QDEPTH), .CHW(CHW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rr(cfg_rr),
        .cfg_fwd_cnt(cfg_fwd_cnt), .cfg_qsize(cfg_qsize),
        .ptr_ld(ptr_ld), .ptr_ld_q(ptr_ld_q), .ptr_ld_val(ptr_ld_val),
        .snoop_wr(snoop_wr), .snoop_q(snoop_q),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cred_inc(cred_inc), .cred_chan(cred_chan)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    logic [WW-1:0] ram [NQ*QDEPTH];
    int cnt [1 << CHW];
    int hits [NQ*QDEPTH];
    int log_ch [64];
    int log_n = 0;
    bit gap_chk = 0, dis_win = 0;
    int gap_bad = 0, rd_dis = 0, last_rd = -1;

    // reference model state
    int  m_st, m_q, m_last, m_chan;
    bit  m_cred;
    bit  m_act [NQ];
    int  m_ptr [NQ];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // synchronous RAM, one-cycle latency
    always @(posedge clk) if (mem_rd) mem_rdata <= ram[mem_addr];

    function automatic bit m_any();
        for (int i = 0; i < NQ; i++) if (m_act[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_pick();
        if (cfg_rr) begin
            for (int i = 1; i <= NQ; i++) if (m_act[(m_last + i) % NQ]) return (m_last + i) % NQ;
        end else begin
            for (int i = NQ - 1; i >= 0; i--) if (m_act[i]) return i;
        end
        return 0;
    endfunction

    // reference model, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_q = 0; m_last = NQ - 1; m_cred = 0; m_chan = 0;
            for (int i = 0; i < NQ; i++) begin m_act[i] = 0; m_ptr[i] = 0; end
        end else begin
            bit nc;
            bit sv;
            nc = 0;
            sv = snoop_wr && cfg_en && (int'(snoop_q) < int'(cfg_fwd_cnt));
            if (m_st == 1) begin
                if (mem_rdata[CHW+1]) begin
                    m_ptr[m_q] = (m_ptr[m_q] + 1 == int'(cfg_qsize)) ? 0 : m_ptr[m_q] + 1;
                    if (!mem_rdata[CHW]) begin nc = 1; m_chan = int'(mem_rdata[CHW-1:0]); end
                end else begin
                    m_act[m_q] = 0;
                end
                m_st = 0;
            end else if (cfg_en && m_any()) begin
                m_q = m_pick(); m_last = m_q; m_st = 1;
            end
            if (ptr_ld) m_ptr[ptr_ld_q] = int'(ptr_ld_val);
            if (sv) m_act[snoop_q] = 1;
            m_cred = nc;
        end
    end

    // compare against the model every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            bit er;
            int ea;
            er = (m_st == 0) && cfg_en && m_any();
            ea = er ? m_pick() * QDEPTH + m_ptr[m_pick()] : 0;
            chk(mem_rd == er, "R3", "read strobe", int'(mem_rd), int'(er));
            if (mem_rd && er) chk(int'(mem_addr) == ea, "R3", "read address", int'(mem_addr), ea);
            chk(cred_inc == m_cred, "R2", "credit strobe", int'(cred_inc), int'(m_cred));
            if (cred_inc && m_cred) chk(int'(cred_chan) == m_chan, "R2", "credit channel", int'(cred_chan), m_chan);
            if (mem_rd) begin
                hits[mem_addr]++;
                if (gap_chk && last_rd >= 0 && cyc - last_rd != 2) gap_bad++;
                last_rd = cyc;
                if (dis_win) rd_dis++;
            end
            if (cred_inc) begin
                cnt[cred_chan]++;
                if (log_n < 64) begin log_ch[log_n] = int'(cred_chan); log_n++; end
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1; errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic put(input int q, input int idx, input bit v, input bit h, input int ch);
        ram[q*QDEPTH + idx] = {v, h, CHW'(ch)};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snoop(input int q);
        @(negedge clk); snoop_wr = 1; snoop_q = QW'(q);
        @(negedge clk); snoop_wr = 0;
    endtask

    initial begin
        rst_n = 0; cfg_en = 0; cfg_rr = 0; cfg_fwd_cnt = 0; cfg_qsize = 0;
        ptr_ld = 0; ptr_ld_q = 0; ptr_ld_val = 0; snoop_wr = 0; snoop_q = 0;
        for (int i = 0; i < NQ*QDEPTH; i++) begin ram[i] = '0; hits[i] = 0; end
        for (int i = 0; i < (1 << CHW); i++) cnt[i] = 0;
        idle(3);
        chk(mem_rd == 0, "R1", "read in reset", int'(mem_rd), 0);
        chk(cred_inc == 0, "R1", "credit in reset", int'(cred_inc), 0);
        rst_n = 1;
        idle(2);
        chk(mem_rd == 0, "R1", "read after reset", int'(mem_rd), 0);
        chk(cred_inc == 0, "R1", "credit after reset", int'(cred_inc), 0);

        cfg_en = 1; cfg_fwd_cnt = 6; cfg_qsize = 8;
        for (int q = 0; q < NQ; q++) begin
            @(negedge clk); ptr_ld = 1; ptr_ld_q = QW'(q); ptr_ld_val = 2;
        end
        @(negedge clk); ptr_ld = 0;

        // R2 / R4 / R12: simple walk of queue 3
        put(3, 2, 1, 0, 'h31); put(3, 3, 1, 0, 'h32); put(3, 4, 1, 0, 'h33);
        gap_chk = 1; last_rd = -1;
        snoop(3); idle(20); gap_chk = 0;
        for (int c = 'h31; c <= 'h33; c++) chk(cnt[c] == 1, "R2", "credit count", cnt[c], 1);
        chk(gap_bad == 0, "R12", "read spacing errors", gap_bad, 0);
        chk(hits[3*QDEPTH+5] == 1, "R4", "end entry reads", hits[3*QDEPTH+5], 1);

        // R3 wrap and R8 held entry
        put(3, 5, 1, 0, 'h34); put(3, 6, 1, 1, 'h35); put(3, 7, 1, 0, 'h36); put(3, 0, 1, 0, 'h37);
        snoop(3); idle(24);
        chk(cnt['h34] == 1 && cnt['h36] == 1 && cnt['h37] == 1, "R3", "credits across wrap",
            cnt['h34] + cnt['h36] + cnt['h37], 3);
        chk(hits[3*QDEPTH+0] == 1, "R3", "wrapped read at index 0", hits[3*QDEPTH], 1);
        chk(hits[3*QDEPTH+5] == 2, "R4", "pointer kept on end entry", hits[3*QDEPTH+5], 2);
        chk(cnt['h35] == 0, "R8", "held entry credit", cnt['h35], 0);
        chk(hits[3*QDEPTH+7] == 1, "R8", "walk passed held entry", hits[3*QDEPTH+7], 1);

        // R5: queue out of range, and snoop while disabled
        put(7, 2, 1, 0, 'h70);
        snoop(7); idle(10);
        chk(hits[7*QDEPTH+2] == 0 && cnt['h70] == 0, "R5", "out-of-range queue reads", hits[7*QDEPTH+2], 0);
        put(2, 2, 1, 0, 'h20);
        cfg_en = 0; snoop(2); idle(4); cfg_en = 1; idle(10);
        chk(hits[2*QDEPTH+2] == 0, "R5", "snoop while disabled", hits[2*QDEPTH+2], 0);

        // R6: strict priority between queues 4 and 1
        put(1, 2, 1, 0, 'h11); put(1, 3, 1, 0, 'h12); put(4, 2, 1, 0, 'h41); put(4, 3, 1, 0, 'h42);
        log_n = 0;
        @(negedge clk); snoop_wr = 1; snoop_q = 4;
        @(negedge clk); snoop_q = 1;
        @(negedge clk); snoop_wr = 0;
        idle(20);
        chk(log_n == 4, "R6", "strict credit total", log_n, 4);
        chk(log_ch[0] == 'h41 && log_ch[1] == 'h42, "R6", "high queue first", log_ch[0], 'h41);
        chk(log_ch[2] == 'h11 && log_ch[3] == 'h12, "R6", "low queue after", log_ch[2], 'h11);

        // R7: rotating order across queues 0, 2, 5
        cfg_rr = 1;
        put(2, 3, 1, 0, 'h21); put(0, 2, 1, 0, 'h01); put(0, 3, 1, 0, 'h02);
        put(5, 2, 1, 0, 'h51); put(5, 3, 1, 0, 'h52);
        log_n = 0;
        @(negedge clk); snoop_wr = 1; snoop_q = 0;
        @(negedge clk); snoop_q = 2;
        @(negedge clk); snoop_q = 5;
        @(negedge clk); snoop_wr = 0;
        idle(30);
        begin
            int exp_seq [6] = '{'h01, 'h20, 'h51, 'h02, 'h21, 'h52};
            chk(log_n == 6, "R7", "rotating credit total", log_n, 6);
            for (int i = 0; i < 6; i++) chk(log_ch[i] == exp_seq[i], "R7", "rotating order", log_ch[i], exp_seq[i]);
        end

        // R10: snoop coincident with the end of a walk
        begin
            int base;
            base = hits[0*QDEPTH+4];
            @(negedge clk); snoop_wr = 1; snoop_q = 0;
            @(negedge clk); snoop_wr = 0;
            @(negedge clk); snoop_wr = 1;
            @(negedge clk); snoop_wr = 0;
            idle(10);
            chk(hits[4] - base == 2, "R10", "end entry re-read", hits[4] - base, 2);
        end

        // R9: load overrides an advance of the same queue
        put(5, 4, 1, 0, 'h53); put(5, 5, 1, 0, 'h54); put(5, 6, 1, 0, 'h55);
        @(negedge clk); snoop_wr = 1; snoop_q = 5;
        @(negedge clk); snoop_wr = 0;
        @(negedge clk); ptr_ld = 1; ptr_ld_q = 5; ptr_ld_val = 6;
        @(negedge clk); ptr_ld = 0;
        idle(15);
        chk(cnt['h53] == 1, "R9", "entry before load", cnt['h53], 1);
        chk(cnt['h54] == 0, "R9", "entry skipped by load", cnt['h54], 0);
        chk(cnt['h55] == 1, "R9", "entry at loaded index", cnt['h55], 1);

        // R11: disable in the middle of a walk
        cfg_rr = 0;
        put(1, 4, 1, 0, 'h101); put(1, 5, 1, 0, 'h102); put(1, 6, 1, 0, 'h103);
        put(1, 7, 1, 0, 'h104); put(1, 0, 1, 0, 'h105);
        snoop(1); idle(4);
        cfg_en = 0; dis_win = 1; idle(10); dis_win = 0; cfg_en = 1;
        idle(20);
        chk(rd_dis == 0, "R11", "reads while disabled", rd_dis, 0);
        for (int c = 'h101; c <= 'h105; c++) chk(cnt[c] == 1, "R11", "walk resumed credit", cnt[c], 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule